// File: doc/BRIEF.md
# Flash Status Verdict Unit

This unit sits beside the command sequencer of a multi-level NAND-style flash controller. When the sequencer has finished a program or an erase and has polled the device's status byte, it pulses a completion strobe. The strobe carries the raw byte and a flag saying which kind of operation it was. The unit masks off the bits that carry no meaning and turns the byte into one verdict: clean pass, error fixable by the system's error-correcting code, error that needs the sector moved to a spare, device still busy, or an inconsistent status (protocol error).

A failed operation leaves an error flag latched in the device, and that flag has to be wiped before the next program or erase. For any error verdict the unit raises a clear request to the sequencer, which then sends the status-clear command. The request stays up until the sequencer acknowledges it. While it is up, the unit reports that no new operation may start and ignores completion strobes. After a failed program the unit also tells the sequencer that recovery-read and recovery-write commands are permitted. Choosing the spare sector and decoding the ECC are left to other logic.

Top module: `flash_status_decider`

## Requirements
- R1: After reset the outputs read as follows: `verdict_valid_o`=0, `verdict_o`=0 (pass), `clear_req_o`=0, `op_allow_o`=1, `recovery_ok_o`=0.
- R2: An accepted strobe whose status bit 7 (ready) is 0 gives verdict 3 (not ready). No clear is requested and no other bit is evaluated.
- R3: Status bits 3..0 are reserved and have no effect on any output.
- R4: With bit 7 set and neither bit 5 (erase fail) nor bit 4 (program fail) set, the verdict is 0 (pass), whatever the value of bit 6.
- R5: With bit 7 set and only the fail bit that matches the operation set (bit 4 for a program, `op_is_erase_i`=0; bit 5 for an erase), the verdict is 1 (ECC-correctable) when bit 6 is 1 and 2 (replace sector) when bit 6 is 0.
- R6: With bit 7 set, the verdict is 4 (protocol error) in two cases: both fail bits are set, or the only fail bit set belongs to the other operation.
- R7: Verdicts 1, 2 and 4 raise `clear_req_o` in the same cycle that `verdict_valid_o` is high. It stays high until `clear_ack_i` is sampled high at a clock edge and is low from the following cycle.
- R8: While `clear_req_o` is high, `op_allow_o` is 0 and a strobe is ignored. It produces no `verdict_valid_o`, and `verdict_o` and `recovery_ok_o` keep their values.
- R9: `recovery_ok_o` goes high together with a verdict of 1 or 2 for a program. Any later accepted strobe replaces it with that strobe's result. It is never set by an erase or by verdicts 0, 3 or 4.
- R10: `verdict_valid_o` is a one-cycle pulse, one clock after an accepted strobe. `verdict_o` holds the latest verdict between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_i | input | 1 | Completion strobe from the sequencer; status and operation valid with it |
| status_i | input | 8 | Raw status byte polled from the flash |
| op_is_erase_i | input | 1 | 1 = finished operation was an erase, 0 = a program |
| clear_ack_i | input | 1 | Sequencer has issued the status-clear command |
| verdict_valid_o | output | 1 | One-cycle pulse: a new verdict is on `verdict_o` |
| verdict_o | output | 3 | 0 pass, 1 ECC-correctable, 2 replace sector, 3 not ready, 4 protocol error |
| clear_req_o | output | 1 | Request to send the status-clear command |
| op_allow_o | output | 1 | A new program or erase may be started |
| recovery_ok_o | output | 1 | Recovery read/write commands are permitted |

## Verification
Assertions check the clear handshake on every cycle: the request holds until acknowledged and drops one cycle after. They also check that no verdict pulse appears without an accepted strobe the cycle before, that no strobe is taken while a clear is pending, and that error verdicts always come with a request while pass and not-ready verdicts never do. How each of the 256 byte values maps to a verdict for each operation type cannot be seen from those properties, and neither can the masking of the reserved bits or the recovery permission. The bench shows these with a full sweep of both operation types, and it also probes strobes sent while a clear is pending.

// File: rtl/flash_stat_pkg.sv
// Package: shared verdict encoding for the flash status verdict unit.
// Assumes: verdict codes are consumed by the sequencer as plain 3-bit values.
package flash_stat_pkg;

    typedef enum logic [2:0] {
        VD_PASS     = 3'd0,
        VD_ECC      = 3'd1,
        VD_SPARE    = 3'd2,
        VD_NOTREADY = 3'd3,
        VD_PROTO    = 3'd4
    } verdict_e;

endpackage

// File: rtl/stat_field_mask.sv
// Module: stat_field_mask
// Zeroes the reserved low bits of the raw status byte so that nothing
// downstream can depend on them.
// Assumes: reserved bits occupy the RSV_W least significant positions.
module stat_field_mask #(
    parameter int STAT_W = 8,
    parameter int RSV_W  = 4
) (
    input  logic [STAT_W-1:0] raw_i,
    output logic [STAT_W-1:0] masked_o
);

    // One mask cell per bit: reserved positions forced low, others pass.
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b < RSV_W) begin : g_rsv
            assign masked_o[b] = 1'b0;
        end else begin : g_keep
            assign masked_o[b] = raw_i[b];
        end
    end

endmodule

// File: rtl/stat_verdict.sv
// Module: stat_verdict
// Combinational classifier: turns a masked status byte and the operation
// type into a verdict, an error flag and a recovery permission.
// Assumes: input already masked; bit positions given by parameters.
module stat_verdict
    import flash_stat_pkg::*;
#(
    parameter int STAT_W  = 8,
    parameter int RDY_BIT = 7,
    parameter int ECC_BIT = 6,
    parameter int ERS_BIT = 5,
    parameter int PGM_BIT = 4
) (
    input  logic [STAT_W-1:0] stat_i,
    input  logic              op_is_erase_i,
    output verdict_e          verdict_o,
    output logic              is_error_o,
    output logic              recov_o
);

    logic ready, ecc_ok, ers_fail, pgm_fail, own_fail, other_fail;

    // Field extraction and fail-bit steering by operation type.
    always_comb begin
        ready      = stat_i[RDY_BIT];
        ecc_ok     = stat_i[ECC_BIT];
        ers_fail   = stat_i[ERS_BIT];
        pgm_fail   = stat_i[PGM_BIT];
        own_fail   = op_is_erase_i ? ers_fail : pgm_fail;
        other_fail = op_is_erase_i ? pgm_fail : ers_fail;
    end

    // Priority decision: busy, then inconsistency, then own failure.
    always_comb begin
        if (!ready) begin
            verdict_o = VD_NOTREADY;
        end else if (other_fail) begin
            verdict_o = VD_PROTO;
        end else if (own_fail) begin
            verdict_o = ecc_ok ? VD_ECC : VD_SPARE;
        end else begin
            verdict_o = VD_PASS;
        end
    end

    // Derived flags for the clear handshake and recovery permission.
    always_comb begin
        is_error_o = (verdict_o == VD_ECC) || (verdict_o == VD_SPARE) ||
                     (verdict_o == VD_PROTO);
        recov_o    = !op_is_erase_i &&
                     ((verdict_o == VD_ECC) || (verdict_o == VD_SPARE));
    end

    // A protocol verdict implies a ready device with some fail bit set.
    always_comb begin
        if (verdict_o == VD_PROTO) begin
            AST_PROTO_NEEDS_FAIL: assert (ready && (ers_fail || pgm_fail)); // R6
        end
    end

endmodule

// File: rtl/stat_clear_ctrl.sv
// Module: stat_clear_ctrl
// Holds the status-clear request from an error verdict until the
// sequencer acknowledges it.
// Assumes: set and ack never meet, because set is gated by op_allow.
module stat_clear_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic req_o
);

    logic req_q;

    // Request flop: set by an error, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (set_i) begin
            req_q <= 1'b1;
        end else if (ack_i) begin
            req_q <= 1'b0;
        end
    end

    assign req_o = req_q;

    AST_CLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_q && !ack_i |=> req_q); // R7
    AST_CLR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        req_q && ack_i && !set_i |=> !req_q); // R7

endmodule

// File: rtl/flash_status_decider.sv
// Module: flash_status_decider (top)
// Evaluates the polled flash status after a program or erase, registers
// a verdict, requests a status clear on errors and blocks new operations
// until the clear is acknowledged.
// Assumes: done_i is a single-cycle strobe with status_i and op_is_erase_i.
module flash_status_decider
    import flash_stat_pkg::*;
#(
    parameter int STAT_W  = 8,
    parameter int RSV_W   = 4,
    parameter int RDY_BIT = STAT_W - 1,
    parameter int ECC_BIT = STAT_W - 2,
    parameter int ERS_BIT = STAT_W - 3,
    parameter int PGM_BIT = STAT_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic              op_is_erase_i,
    input  logic              clear_ack_i,
    output logic              verdict_valid_o,
    output logic [2:0]        verdict_o,
    output logic              clear_req_o,
    output logic              op_allow_o,
    output logic              recovery_ok_o
);

    logic [STAT_W-1:0] stat_m;
    verdict_e          vd_now;
    verdict_e          vd_q;
    logic              err_now, recov_now, accept;
    logic              vld_q, recov_q;

    stat_field_mask #(.STAT_W(STAT_W), .RSV_W(RSV_W)) i_mask (
        .raw_i    (status_i),
        .masked_o (stat_m)
    );

    stat_verdict #(
        .STAT_W(STAT_W), .RDY_BIT(RDY_BIT), .ECC_BIT(ECC_BIT),
        .ERS_BIT(ERS_BIT), .PGM_BIT(PGM_BIT)
    ) i_verdict (
        .stat_i        (stat_m),
        .op_is_erase_i (op_is_erase_i),
        .verdict_o     (vd_now),
        .is_error_o    (err_now),
        .recov_o       (recov_now)
    );

    // Strobes are only honoured when no clear is outstanding.
    assign accept = done_i && !clear_req_o;

    stat_clear_ctrl i_clear (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (accept && err_now),
        .ack_i (clear_ack_i),
        .req_o (clear_req_o)
    );

    // Verdict, pulse and recovery registers updated on accepted strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vd_q    <= VD_PASS;
            vld_q   <= 1'b0;
            recov_q <= 1'b0;
        end else begin
            vld_q <= accept;
            if (accept) begin
                vd_q    <= vd_now;
                recov_q <= recov_now;
            end
        end
    end

    assign verdict_valid_o = vld_q;
    assign verdict_o       = vd_q;
    assign recovery_ok_o   = recov_q;
    assign op_allow_o      = !clear_req_o;

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid_o |-> $past(done_i && op_allow_o)); // R10
    AST_IGNORE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req_o && done_i |=> !verdict_valid_o && $stable(verdict_o)); // R8
    AST_ERR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid_o && (verdict_o == 3'd1 || verdict_o == 3'd2 ||
        verdict_o == 3'd4) |-> clear_req_o); // R7
    AST_OK_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid_o && (verdict_o == 3'd0 || verdict_o == 3'd3)
        |-> !clear_req_o); // R2
    AST_RECOV_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recovery_ok_o) |-> verdict_valid_o &&
        (verdict_o == 3'd1 || verdict_o == 3'd2)); // R9

endmodule

// File: tb/test_flash_status_decider.sv
module test_flash_status_decider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       done_i = 1'b0;
    logic [7:0] status_i = 8'h00;
    logic       op_is_erase_i = 1'b0;
    logic       clear_ack_i = 1'b0;
    logic       verdict_valid_o;
    logic [2:0] verdict_o;
    logic       clear_req_o;
    logic       op_allow_o;
    logic       recovery_ok_o;

    int n_chk = 0;
    int n_err = 0;
    logic done_flag = 1'b0;

    flash_status_decider i_flash_status_decider (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .status_i(status_i),
        .op_is_erase_i(op_is_erase_i), .clear_ack_i(clear_ack_i),
        .verdict_valid_o(verdict_valid_o), .verdict_o(verdict_o),
        .clear_req_o(clear_req_o), .op_allow_o(op_allow_o),
        .recovery_ok_o(recovery_ok_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected verdict from the requirements.
    function automatic int exp_verdict(input logic [7:0] s, input logic ers);
        logic own, oth;
        if (!s[7]) return 3;                  // R2
        own = ers ? s[5] : s[4];
        oth = ers ? s[4] : s[5];
        if (oth) return 4;                    // R6
        if (own) return s[6] ? 1 : 2;         // R5
        return 0;                             // R4
    endfunction

    initial begin
        int prev_v;
        int prev_r;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", verdict_valid_o, 0);
        check("R1 verdict", verdict_o, 0);
        check("R1 clear_req", clear_req_o, 0);
        check("R1 op_allow", op_allow_o, 1);
        check("R1 recovery", recovery_ok_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int op = 0; op < 2; op++) begin
            for (int s = 0; s < 256; s++) begin
                int ev, er, ec;
                ev = exp_verdict(s[7:0], op[0]);
                ec = (ev == 1 || ev == 2 || ev == 4) ? 1 : 0;
                er = (op == 0 && (ev == 1 || ev == 2)) ? 1 : 0;
                done_i = 1'b1; status_i = s[7:0]; op_is_erase_i = op[0];
                @(negedge clk);
                done_i = 1'b0;
                // R10 pulse, R3 via full sweep of low bits
                check("R10 valid pulse", verdict_valid_o, 1);
                check((s[3:0] != 0) ? "R3 masked verdict" : "R4/R5/R6 verdict",
                      verdict_o, ev);
                check("R7 clear_req", clear_req_o, ec);
                check("R9 recovery", recovery_ok_o, er);
                if (ec == 1) begin
                    prev_v = verdict_o;
                    prev_r = recovery_ok_o;
                    // R8: strobe while clear pending is ignored
                    done_i = 1'b1; status_i = 8'h80; op_is_erase_i = ~op[0];
                    @(negedge clk);
                    done_i = 1'b0;
                    check("R8 op_allow", op_allow_o, 0);
                    check("R8 no valid", verdict_valid_o, 0);
                    check("R8 verdict held", verdict_o, prev_v);
                    check("R8 recovery held", recovery_ok_o, prev_r);
                    check("R7 req held", clear_req_o, 1);
                    clear_ack_i = 1'b1;
                    @(negedge clk);
                    clear_ack_i = 1'b0;
                    check("R7 req dropped", clear_req_o, 0);
                    check("R8 op_allow back", op_allow_o, 1);
                end else begin
                    @(negedge clk);
                    check("R10 single pulse", verdict_valid_o, 0);
                    check("R10 verdict held", verdict_o, ev);
                end
            end
        end
        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (100000) @(posedge clk);
                n_err++;
                n_chk++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule